// File: doc/BRIEF.md
# L1 Lock Word Controller

This block is the private-cache side of a distributed queue lock for one lock word. It takes the local core's acquire and release requests, lock grants that come back from the shared cache or from a peer core, and lock requests that other cores forward to it. It keeps an ownership state, a "held" flag and a single waiter slot. An acquire that misses stalls the core until a grant arrives. A release that finds a waiter passes the lock straight to that core, without going through the shared cache.

Along with the lock it carries an access signature. This is a small hashed bit set of the addresses this core wrote atomically in the current phase. A grant brings in the releaser's signature, which is OR-merged into the local one. Every hand-off and every signature-only request sends out a copy of the local signature. The end of a phase clears the signature. Requests that arrive in a state that cannot serve them are refused with a Nack to the shared cache.

The design consumes at most one event per cycle. All outward pulses are registered and appear in the cycle after the edge that takes the event.

Top module: `l1_lock_word_ctrl`

## Requirements
- R1: After reset the controller is not owner and not waiting: `core_stall`=0, `lock_held`=0, every outward pulse is 0, and the signature is all zeros.
- R2: `lcl_acq` while not owner and not waiting latches `lcl_tag`. In the next cycle it raises `l2_acq` for one cycle, with `l2_acq_wb`=`lcl_wb_need` and `l2_tag` equal to the tag. `core_stall` rises and stays high while waiting. Local requests made while waiting have no effect.
- R3: A grant (`gnt_valid`) while waiting drops `core_stall`, sets `lock_held`, and ORs `gnt_sig` into the signature.
- R4: `lcl_rel` while held with a recorded waiter sends one `fwd_valid` pulse with `fwd_sig_only`=0, `fwd_core` = the waiter and `fwd_sig` = the signature. It clears `lock_held`, gives up ownership and empties the waiter slot.
- R5: `lcl_rel` while held with no waiter only clears `lock_held`, and no pulse is sent. A later `lcl_acq` sets `lock_held` again with no `l2_acq` and no stall.
- R6: A full remote request (`rmt_sig_only`=0) while held, or while waiting, is stored as the waiter if the slot is empty. If the slot is occupied, the next cycle gives `l2_nack`=1 with `l2_nack_core` = the requester.
- R7: A full remote request while owner but not held is granted at once through `fwd_valid` with the signature, and ownership is given up.
- R8: While not owner and not waiting, a signature-only remote request is answered by `fwd_valid` with `fwd_sig_only`=1 and `fwd_sig` = the signature. A full remote request is answered by `l2_nack` naming the requester.
- R9: `lcl_rel` while not owner and not waiting gives a one-cycle `l2_rel` pulse.
- R10: `wr_ins` sets signature bit h(`wr_addr`). In the XOR-fold variant, h(`wr_addr`) is the XOR of the address split into log2(SIG_W)-bit chunks from bit 0 upward, with the top chunk zero-padded. `phase_end` clears the signature, and an insert or merge in the same cycle is lost.
- R11: Events have a fixed priority: grant, then remote request, then local request. A lower-priority event in the same cycle is dropped. At most one of `l2_acq`, `l2_rel`, `l2_nack`, `fwd_valid` is high in any cycle.
- R12: A signature-only remote request while waiting or owner is refused with `l2_nack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lcl_acq | input | 1 | Local core acquire request |
| lcl_rel | input | 1 | Local core release request |
| lcl_tag | input | ADDR_W | Lock word address for an acquire |
| lcl_wb_need | input | 1 | The victim line needs a writeback |
| wr_ins | input | 1 | Atomic write to be recorded in the signature |
| wr_addr | input | ADDR_W | Address of that atomic write |
| phase_end | input | 1 | Phase boundary: clear the signature |
| gnt_valid | input | 1 | Lock grant arrives |
| gnt_sig | input | SIG_W | Signature carried by the grant |
| rmt_valid | input | 1 | Remote lock request arrives |
| rmt_core | input | CID_W | Requesting core |
| rmt_sig_only | input | 1 | The remote request only wants the signature |
| core_stall | output | 1 | Stall to the local core |
| lock_held | output | 1 | Lock is held by the local core |
| l2_acq | output | 1 | Lock request to the shared cache |
| l2_acq_wb | output | 1 | Writeback flag for that request |
| l2_rel | output | 1 | Unlock request to the shared cache |
| l2_tag | output | ADDR_W | Latched lock word address |
| l2_nack | output | 1 | Nack to the shared cache |
| l2_nack_core | output | CID_W | Core whose request was refused |
| fwd_valid | output | 1 | Grant or signature sent to a peer |
| fwd_core | output | CID_W | Destination core |
| fwd_sig_only | output | 1 | Signature-only response, not a lock grant |
| fwd_sig | output | SIG_W | Signature sent |

## Verification
The bench builds the block with NUM_CORES=4, SIG_W=16, ADDR_W=8 and the XOR-fold hash. With these values all 256 addresses can be inserted one at a time, and each resulting signature is read back through a signature-only request. Every core number is swept through the Nack and hand-off paths. The small signature also makes merge results easy to predict bit by bit as OR patterns, across full acquire, hand-off and local re-acquire cycles, and for the events that collide in one cycle.

// File: rtl/lkw_pkg.sv
package lkw_pkg;
   typedef enum logic [1:0] {
      LW_INV  = 2'd0,
      LW_WAIT = 2'd1,
      LW_OWN  = 2'd2
   } lw_state_e;

   localparam int unsigned HASH_LOW  = 0;
   localparam int unsigned HASH_FOLD = 1;
endpackage

// File: rtl/lkw_sig_hash.sv
module lkw_sig_hash #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned SIG_W     = 256,
   parameter int unsigned HASH_MODE = 1
) (
   input  logic [ADDR_W-1:0]        addr,
   output logic [$clog2(SIG_W)-1:0] idx
);
   localparam int unsigned IDX_W = $clog2(SIG_W);
   localparam int unsigned NCH   = (ADDR_W + IDX_W - 1) / IDX_W;
   localparam int unsigned PAD_W = NCH * IDX_W;

   logic [PAD_W-1:0] padded;
   assign padded = PAD_W'(addr);

   generate
      if (HASH_MODE == lkw_pkg::HASH_LOW) begin : g_low
         assign idx = padded[IDX_W-1:0];
      end else begin : g_fold
         always_comb begin
            idx = '0;
            for (int c = 0; c < int'(NCH); c++) begin
               idx = idx ^ padded[c*IDX_W +: IDX_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lkw_sig_store.sv
module lkw_sig_store #(
   parameter int unsigned SIG_W = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     ins,
   input  logic [$clog2(SIG_W)-1:0] ins_idx,
   input  logic                     mrg,
   input  logic [SIG_W-1:0]         mrg_vec,
   output logic [SIG_W-1:0]         sig_q
);
   logic [SIG_W-1:0] ins_vec;
   logic [SIG_W-1:0] sig_d;

   always_comb begin
      ins_vec = '0;
      ins_vec[ins_idx] = ins;
   end

   always_comb begin
      if (clr) sig_d = '0;
      else     sig_d = sig_q | ins_vec | (mrg ? mrg_vec : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= '0;
      else        sig_q <= sig_d;
   end
endmodule

// File: rtl/lkw_waiter_slot.sv
module lkw_waiter_slot #(
   parameter int unsigned CID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic [CID_W-1:0] set_id,
   input  logic             clr,
   output logic             vld,
   output logic [CID_W-1:0] id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         id  <= '0;
      end else if (clr) begin
         vld <= 1'b0;
         id  <= '0;
      end else if (set) begin
         vld <= 1'b1;
         id  <= set_id;
      end
   end
endmodule

// File: rtl/lkw_fsm.sv
module lkw_fsm
   import lkw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SIG_W  = 256,
   parameter int unsigned CID_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lcl_acq,
   input  logic              lcl_rel,
   input  logic [ADDR_W-1:0] lcl_tag,
   input  logic              lcl_wb_need,
   input  logic              gnt_valid,
   input  logic              rmt_valid,
   input  logic [CID_W-1:0]  rmt_core,
   input  logic              rmt_sig_only,
   input  logic [SIG_W-1:0]  sig_q,
   input  logic              slot_vld,
   input  logic [CID_W-1:0]  slot_id,
   output logic              slot_set,
   output logic              slot_clr,
   output logic              mrg,
   output lw_state_e         st_q,
   output logic              held_q,
   output logic              l2_acq,
   output logic              l2_acq_wb,
   output logic              l2_rel,
   output logic [ADDR_W-1:0] l2_tag,
   output logic              l2_nack,
   output logic [CID_W-1:0]  l2_nack_core,
   output logic              fwd_valid,
   output logic [CID_W-1:0]  fwd_core,
   output logic              fwd_sig_only,
   output logic [SIG_W-1:0]  fwd_sig
);
   logic take_gnt, take_rmt, take_acq, take_rel;
   lw_state_e st_d;
   logic held_d, tag_ld;
   logic acq_d, rel_d, nack_d, fwd_d, fwd_so_d;
   logic [CID_W-1:0] nack_id_d, fwd_id_d;

   assign take_gnt = gnt_valid;
   assign take_rmt = rmt_valid && !gnt_valid;
   assign take_acq = lcl_acq && !gnt_valid && !rmt_valid;
   assign take_rel = lcl_rel && !lcl_acq && !gnt_valid && !rmt_valid;

   always_comb begin
      st_d      = st_q;
      held_d    = held_q;
      tag_ld    = 1'b0;
      acq_d     = 1'b0;
      rel_d     = 1'b0;
      nack_d    = 1'b0;
      nack_id_d = rmt_core;
      fwd_d     = 1'b0;
      fwd_so_d  = 1'b0;
      fwd_id_d  = rmt_core;
      slot_set  = 1'b0;
      mrg       = 1'b0;
      unique case (st_q)
         LW_INV: begin
            if (take_rmt) begin
               if (rmt_sig_only) begin
                  fwd_d    = 1'b1;
                  fwd_so_d = 1'b1;
               end else begin
                  nack_d = 1'b1;
               end
            end else if (take_acq) begin
               tag_ld = 1'b1;
               acq_d  = 1'b1;
               st_d   = LW_WAIT;
            end else if (take_rel) begin
               rel_d = 1'b1;
            end
         end
         LW_WAIT: begin
            if (take_gnt) begin
               mrg    = 1'b1;
               held_d = 1'b1;
               st_d   = LW_OWN;
            end else if (take_rmt) begin
               if (rmt_sig_only || slot_vld) nack_d   = 1'b1;
               else                          slot_set = 1'b1;
            end
         end
         LW_OWN: begin
            if (take_rmt) begin
               if (rmt_sig_only) begin
                  nack_d = 1'b1;
               end else if (held_q) begin
                  if (slot_vld) nack_d   = 1'b1;
                  else          slot_set = 1'b1;
               end else begin
                  fwd_d = 1'b1;
                  st_d  = LW_INV;
               end
            end else if (take_acq) begin
               held_d = 1'b1;
            end else if (take_rel && held_q) begin
               held_d = 1'b0;
               if (slot_vld) begin
                  fwd_d    = 1'b1;
                  fwd_id_d = slot_id;
                  st_d     = LW_INV;
               end
            end
         end
         default: st_d = LW_INV;
      endcase
      if (st_d == LW_INV) held_d = 1'b0;
   end

   assign slot_clr = (st_d == LW_INV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= LW_INV;
         held_q       <= 1'b0;
         l2_tag       <= '0;
         l2_acq       <= 1'b0;
         l2_acq_wb    <= 1'b0;
         l2_rel       <= 1'b0;
         l2_nack      <= 1'b0;
         l2_nack_core <= '0;
         fwd_valid    <= 1'b0;
         fwd_core     <= '0;
         fwd_sig_only <= 1'b0;
         fwd_sig      <= '0;
      end else begin
         st_q         <= st_d;
         held_q       <= held_d;
         if (tag_ld) l2_tag <= lcl_tag;
         l2_acq       <= acq_d;
         l2_acq_wb    <= acq_d && lcl_wb_need;
         l2_rel       <= rel_d;
         l2_nack      <= nack_d;
         l2_nack_core <= nack_d ? nack_id_d : '0;
         fwd_valid    <= fwd_d;
         fwd_core     <= fwd_d ? fwd_id_d : '0;
         fwd_sig_only <= fwd_so_d;
         fwd_sig      <= fwd_d ? sig_q : '0;
      end
   end
endmodule

// File: rtl/l1_lock_word_ctrl.sv
module l1_lock_word_ctrl
   import lkw_pkg::*;
#(
   parameter int unsigned NUM_CORES = 16,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned SIG_W     = 256,
   parameter int unsigned HASH_MODE = 1,
   localparam int unsigned CID_W    = $clog2(NUM_CORES),
   localparam int unsigned IDX_W    = $clog2(SIG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lcl_acq,
   input  logic              lcl_rel,
   input  logic [ADDR_W-1:0] lcl_tag,
   input  logic              lcl_wb_need,
   input  logic              wr_ins,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              phase_end,
   input  logic              gnt_valid,
   input  logic [SIG_W-1:0]  gnt_sig,
   input  logic              rmt_valid,
   input  logic [CID_W-1:0]  rmt_core,
   input  logic              rmt_sig_only,
   output logic              core_stall,
   output logic              lock_held,
   output logic              l2_acq,
   output logic              l2_acq_wb,
   output logic              l2_rel,
   output logic [ADDR_W-1:0] l2_tag,
   output logic              l2_nack,
   output logic [CID_W-1:0]  l2_nack_core,
   output logic              fwd_valid,
   output logic [CID_W-1:0]  fwd_core,
   output logic              fwd_sig_only,
   output logic [SIG_W-1:0]  fwd_sig
);
   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("NUM_CORES must be at least 2");
      end
      if (SIG_W < 2 || (SIG_W & (SIG_W - 1)) != 0) begin : g_bad_sig
         $error("SIG_W must be a power of two, at least 2");
      end
      if (HASH_MODE > 1) begin : g_bad_hash
         $error("HASH_MODE must be 0 or 1");
      end
   endgenerate

   lw_state_e        st_q;
   logic [SIG_W-1:0] sig_q;
   logic [IDX_W-1:0] ins_idx;
   logic             slot_vld, slot_set, slot_clr, mrg;
   logic [CID_W-1:0] slot_id;

   lkw_sig_hash #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .HASH_MODE(HASH_MODE)) u_hash (
      .addr (wr_addr),
      .idx  (ins_idx)
   );

   lkw_sig_store #(.SIG_W(SIG_W)) u_sig (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (phase_end),
      .ins     (wr_ins),
      .ins_idx (ins_idx),
      .mrg     (mrg),
      .mrg_vec (gnt_sig),
      .sig_q   (sig_q)
   );

   lkw_waiter_slot #(.CID_W(CID_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (slot_set),
      .set_id (rmt_core),
      .clr    (slot_clr),
      .vld    (slot_vld),
      .id     (slot_id)
   );

   lkw_fsm #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .CID_W(CID_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lcl_acq      (lcl_acq),
      .lcl_rel      (lcl_rel),
      .lcl_tag      (lcl_tag),
      .lcl_wb_need  (lcl_wb_need),
      .gnt_valid    (gnt_valid),
      .rmt_valid    (rmt_valid),
      .rmt_core     (rmt_core),
      .rmt_sig_only (rmt_sig_only),
      .sig_q        (sig_q),
      .slot_vld     (slot_vld),
      .slot_id      (slot_id),
      .slot_set     (slot_set),
      .slot_clr     (slot_clr),
      .mrg          (mrg),
      .st_q         (st_q),
      .held_q       (lock_held),
      .l2_acq       (l2_acq),
      .l2_acq_wb    (l2_acq_wb),
      .l2_rel       (l2_rel),
      .l2_tag       (l2_tag),
      .l2_nack      (l2_nack),
      .l2_nack_core (l2_nack_core),
      .fwd_valid    (fwd_valid),
      .fwd_core     (fwd_core),
      .fwd_sig_only (fwd_sig_only),
      .fwd_sig      (fwd_sig)
   );

   assign core_stall = (st_q == LW_WAIT);
endmodule

// File: rtl/l1_lock_word_ctrl_chk.sv
module l1_lock_word_ctrl_chk #(
   parameter int unsigned SIG_W = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       st,
   input logic [SIG_W-1:0] sig_q,
   input logic             gnt_valid,
   input logic [SIG_W-1:0] gnt_sig,
   input logic             rmt_valid,
   input logic             phase_end,
   input logic             core_stall,
   input logic             lock_held,
   input logic             l2_acq,
   input logic             l2_rel,
   input logic             l2_nack,
   input logic             fwd_valid,
   input logic             fwd_sig_only
);
   assert_stall_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_stall) |-> l2_acq);

   assert_grant_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_stall && gnt_valid |=> !core_stall && lock_held);

   assert_grant_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_stall && gnt_valid && !phase_end |=> ((sig_q & $past(gnt_sig)) == $past(gnt_sig)));

   assert_handoff_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid && !fwd_sig_only |-> !lock_held && st == lkw_pkg::LW_INV);

   assert_held_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_held |-> st == lkw_pkg::LW_OWN);

   assert_inv_answers_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st == lkw_pkg::LW_INV && rmt_valid && !gnt_valid |=> fwd_valid || l2_nack);

   assert_phase_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      phase_end |=> sig_q == '0);

   assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({l2_acq, l2_rel, l2_nack, fwd_valid}));
endmodule

bind l1_lock_word_ctrl l1_lock_word_ctrl_chk #(.SIG_W(SIG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st           (st_q),
   .sig_q        (sig_q),
   .gnt_valid    (gnt_valid),
   .gnt_sig      (gnt_sig),
   .rmt_valid    (rmt_valid),
   .phase_end    (phase_end),
   .core_stall   (core_stall),
   .lock_held    (lock_held),
   .l2_acq       (l2_acq),
   .l2_rel       (l2_rel),
   .l2_nack      (l2_nack),
   .fwd_valid    (fwd_valid),
   .fwd_sig_only (fwd_sig_only)
);

// File: tb/l1_lock_word_ctrl_tb.sv
module l1_lock_word_ctrl_tb;
   localparam int NC = 4;
   localparam int AW = 8;
   localparam int SW = 16;
   localparam int CW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lcl_acq, lcl_rel, lcl_wb_need, wr_ins, phase_end, gnt_valid, rmt_valid, rmt_sig_only;
   logic [AW-1:0] lcl_tag, wr_addr;
   logic [SW-1:0] gnt_sig;
   logic [CW-1:0] rmt_core;
   logic core_stall, lock_held, l2_acq, l2_acq_wb, l2_rel, l2_nack, fwd_valid, fwd_sig_only;
   logic [AW-1:0] l2_tag;
   logic [CW-1:0] l2_nack_core, fwd_core;
   logic [SW-1:0] fwd_sig;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   l1_lock_word_ctrl #(.NUM_CORES(NC), .ADDR_W(AW), .SIG_W(SW), .HASH_MODE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .lcl_acq(lcl_acq), .lcl_rel(lcl_rel), .lcl_tag(lcl_tag),
      .lcl_wb_need(lcl_wb_need), .wr_ins(wr_ins), .wr_addr(wr_addr), .phase_end(phase_end),
      .gnt_valid(gnt_valid), .gnt_sig(gnt_sig), .rmt_valid(rmt_valid), .rmt_core(rmt_core),
      .rmt_sig_only(rmt_sig_only), .core_stall(core_stall), .lock_held(lock_held),
      .l2_acq(l2_acq), .l2_acq_wb(l2_acq_wb), .l2_rel(l2_rel), .l2_tag(l2_tag),
      .l2_nack(l2_nack), .l2_nack_core(l2_nack_core), .fwd_valid(fwd_valid),
      .fwd_core(fwd_core), .fwd_sig_only(fwd_sig_only), .fwd_sig(fwd_sig));

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic idle();
      lcl_acq = 0; lcl_rel = 0; lcl_tag = '0; lcl_wb_need = 0;
      wr_ins = 0; wr_addr = '0; phase_end = 0;
      gnt_valid = 0; gnt_sig = '0;
      rmt_valid = 0; rmt_core = '0; rmt_sig_only = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   function automatic int hidx(int a);
      return (a & 15) ^ ((a >> 4) & 15);
   endfunction

   function automatic int pulses();
      return int'(l2_acq) + int'(l2_rel) + int'(l2_nack) + int'(fwd_valid);
   endfunction

   task automatic read_sig(input int exp, input string rq);
      rmt_valid = 1; rmt_sig_only = 1; rmt_core = 2'd1;
      step();
      chk(fwd_valid && fwd_sig_only && fwd_core == 2'd1, "R8", {fwd_valid, fwd_sig_only}, 3);
      chk(fwd_sig == SW'(exp), rq, fwd_sig, exp);
   endtask

   task automatic acquire(input int tag, input bit wb);
      lcl_acq = 1; lcl_tag = AW'(tag); lcl_wb_need = wb;
      step();
      chk(l2_acq && l2_acq_wb == wb && l2_tag == AW'(tag), "R2", {l2_acq, l2_acq_wb, l2_tag}, {1'b1, wb, 8'(tag)});
      chk(core_stall && !lock_held, "R2", core_stall, 1);
   endtask

   task automatic grant(input int s);
      gnt_valid = 1; gnt_sig = SW'(s);
      step();
      chk(!core_stall && lock_held && pulses() == 0, "R3", {core_stall, lock_held}, 1);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int sig;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk(!core_stall && !lock_held && pulses() == 0, "R1", {core_stall, lock_held}, 0);
      read_sig(0, "R1");

      // R10 sweep every address through the fold hash
      for (int a = 0; a < 256; a++) begin
         phase_end = 1; step();
         wr_ins = 1; wr_addr = AW'(a); step();
         read_sig(1 << hidx(a), "R10");
      end
      wr_ins = 1; wr_addr = 8'h12; step();
      wr_ins = 1; wr_addr = 8'hC0; step();
      read_sig((1 << 3) | (1 << 12) | (1 << hidx(255)), "R10");
      phase_end = 1; wr_ins = 1; wr_addr = 8'h01; step();
      read_sig(0, "R10");

      // R9 release while not owner
      lcl_rel = 1; step();
      chk(l2_rel && pulses() == 1, "R9", l2_rel, 1);

      // R8 full remote request refused, every core
      for (int k = 0; k < NC; k++) begin
         rmt_valid = 1; rmt_core = CW'(k); step();
         chk(l2_nack && l2_nack_core == CW'(k) && !fwd_valid, "R8", l2_nack_core, k);
      end

      // R2 / R12 / R6 / R3 / R4
      wr_ins = 1; wr_addr = 8'h03; step();
      sig = 16'h0008;
      acquire(8'h5A, 1);
      lcl_acq = 1; lcl_tag = 8'h11; step();
      chk(pulses() == 0 && core_stall && l2_tag == 8'h5A, "R2", l2_tag, 8'h5A);
      rmt_valid = 1; rmt_sig_only = 1; rmt_core = 2'd3; step();
      chk(l2_nack && l2_nack_core == 2'd3, "R12", l2_nack_core, 3);
      rmt_valid = 1; rmt_core = 2'd2; step();
      chk(pulses() == 0, "R6", pulses(), 0);
      grant(16'h0F00);
      sig = sig | 16'h0F00;
      rmt_valid = 1; rmt_core = 2'd1; step();
      chk(l2_nack && l2_nack_core == 2'd1, "R6", l2_nack_core, 1);
      rmt_valid = 1; rmt_sig_only = 1; step();
      chk(l2_nack && !fwd_valid, "R12", l2_nack, 1);
      lcl_rel = 1; step();
      chk(fwd_valid && !fwd_sig_only && fwd_core == 2'd2, "R4", fwd_core, 2);
      chk(fwd_sig == SW'(sig), "R4", fwd_sig, sig);
      chk(!lock_held && !core_stall, "R4", lock_held, 0);

      // back in Invalid: new acquire goes to L2, waiter slot was emptied
      acquire(8'hA5, 0);
      grant(16'h0001);
      sig = sig | 1;
      // R5 release with no waiter
      lcl_rel = 1; step();
      chk(!lock_held && pulses() == 0, "R5", lock_held, 0);
      lcl_acq = 1; lcl_tag = 8'h77; step();
      chk(lock_held && !core_stall && pulses() == 0, "R5", lock_held, 1);
      lcl_rel = 1; step();
      chk(!lock_held && pulses() == 0, "R5", lock_held, 0);

      // R7 remote grant while owner but not held, every core
      for (int k = 0; k < NC; k++) begin
         rmt_valid = 1; rmt_core = CW'(k); step();
         chk(fwd_valid && !fwd_sig_only && fwd_core == CW'(k), "R7", fwd_core, k);
         chk(fwd_sig == SW'(sig), "R7", fwd_sig, sig);
         read_sig(sig, "R7");
         acquire(k, k[0]);
         grant(16'h0100 << k);
         sig = sig | (16'h0100 << k);
         lcl_rel = 1; step();
      end

      // R11 remote beats local in Invalid
      rmt_valid = 1; rmt_core = 2'd0; step();
      rmt_valid = 1; rmt_core = 2'd3; lcl_acq = 1; lcl_tag = 8'h44; step();
      chk(l2_nack && !l2_acq && !core_stall, "R11", {l2_nack, l2_acq}, 2);
      // R11 grant beats remote while waiting
      acquire(8'h44, 0);
      gnt_valid = 1; gnt_sig = 16'h8000; rmt_valid = 1; rmt_core = 2'd1; step();
      chk(lock_held && pulses() == 0, "R11", lock_held, 1);
      sig = sig | 16'h8000;
      lcl_rel = 1; step();
      chk(!fwd_valid && !lock_held, "R11", fwd_valid, 0);

      // R1 reset again from an owned state
      rst_n = 0; step(); rst_n = 1;
      chk(!core_stall && !lock_held && pulses() == 0, "R1", lock_held, 0);
      read_sig(0, "R1");

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule